// File: doc/BRIEF.md
# Dual-Issue Pairing Front End

This block sits between instruction memory and the execution pipes of an in-order core that can start two instructions per cycle. A fetch unit reads instructions two at a time from addresses that are multiples of 8 bytes. It pushes them into a small in-order queue. A pairing stage looks at the two oldest queued instructions and decides whether both can start together. It bases that decision on which physical pipe each instruction needs and on whether the younger instruction reads a register the older one writes. The result is one issue group: the older instruction alone, or both. Each instruction in the group carries the pipe it is routed to.

Pairing always begins at the oldest queued instruction, whatever its address. A run that starts on the odd word of an aligned pair therefore has its first instruction issue alone, and the groups after it straddle fetch pairs. When a pair is refused, the younger instruction becomes the first slot of the next group. A `start` pulse flushes everything in flight and redirects fetch.

Both data-carrying edges use valid/ready. On the fetch request, `fetch_req` stays high with a stable `fetch_addr` until `fetch_gnt` is seen high at a clock edge. The two instruction words must be present on that same cycle. On the issue edge, the group stays presented, unchanged, while `iss_ready` is low. A group is consumed only at an edge where both `iss_valid` and `iss_ready` are high. A group shown in a cycle where `start` is high is discarded.

Top module: `dual_issue_pairer`

## Requirements
- R1: After reset and until the first `start`, `iss_valid` and `fetch_req` are both 0.
- R2: `fetch_addr` is always a multiple of 8. The first request after `start` is at the start byte address rounded down to 8, and each grant advances it by 8. A start on an odd word drops the lower word of the first pair. `start_addr` is a word address, equal to the byte address divided by 4.
- R3: Two integer instructions (class 0 no-op or class 1 ALU) pair. The older one goes to pipe 1 (integer 0) and the younger one to pipe 2 (integer 1). Instruction word layout: class in bits [17:15], destination in [14:10], source A in [9:5], source B in [4:0].
- R4: Two FP instructions (class 4, pipe 5) never pair. FP pairs with class 0, 1, 2 (load/store, pipe 3) or 3 (branch, pipe 4). It does not pair with class 5 (coprocessor move, pipe 6) or class 6.
- R5: A multimedia instruction (class 6) is routed to pipe 7, which takes both integer pipes. It pairs only with class 2, 3 or 5, and never with a no-op or an ALU instruction.
- R6: Two load/stores, two branches or two coprocessor moves never pair. Class 7 (serial) never pairs and issues on pipe 1.
- R7: If the younger instruction's source A or source B equals the older one's destination, the pair is refused. This does not apply when that destination is register 0.
- R8: When a pair is refused, the next group accepted begins with the younger instruction: its `iss_pc` is 4 more than the refused group's `iss_pc`.
- R9: A paired class 0 or 1 instruction in the second slot goes to pipe 1 if the first slot is not class 0 or 1. `iss_pipe1` is 0 for a single-instruction group, and `iss_dual` is 1 exactly when a group holds two instructions.
- R10: With a fully pairable stream and no back-pressure, a start at a multiple of 8 issues 8 instructions as 4 dual groups on 4 consecutive cycles. A start 4 bytes past such an address needs 5 groups, the first one single.
- R11: While `iss_ready` is low the presented group is held. Under any pattern of `iss_ready` and `fetch_gnt`, accepted groups cover consecutive addresses with no gap or repeat.
- R12: A `start` while a stream is in flight discards it: the next group presented begins at the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Flush and redirect fetch |
| start_addr | input | AW-2 | Word address to run from |
| fetch_req | output | 1 | Fetch request valid |
| fetch_gnt | input | 1 | Fetch request ready; data present this cycle |
| fetch_addr | output | AW | Byte address of the aligned pair |
| fetch_lo | input | 18 | Instruction at fetch_addr |
| fetch_hi | input | 18 | Instruction at fetch_addr+4 |
| iss_valid | output | 1 | Issue group valid |
| iss_ready | input | 1 | Issue group accepted |
| iss_dual | output | 1 | Group holds two instructions |
| iss_pc | output | AW | Byte address of the older instruction |
| iss_pipe0 | output | 3 | Pipe of the older instruction |
| iss_pipe1 | output | 3 | Pipe of the younger instruction, 0 if none |

## Verification
The fetch grant that pushes a new pair into the queue and the issue handshake that pops one or two instructions can land on the same clock edge. The queue then takes a push and a pop at once, possibly wrapping around. The bench provokes this by running a pairable stream while driving `fetch_gnt` and `iss_ready` low in patterns with different periods, so every overlap of grant, stall and accept occurs. It judges the result by the addresses of accepted groups: each one must equal the previous plus 4 per instruction consumed, with every group dual.

// File: rtl/dip_pkg.sv
package dip_pkg;
  localparam int CLS_W  = 3;
  localparam int REG_W  = 5;
  localparam int INS_W  = CLS_W + 3 * REG_W;
  localparam int PIPE_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CL_NOP   = 3'd0,
    CL_ALU   = 3'd1,
    CL_LDST  = 3'd2,
    CL_BRN   = 3'd3,
    CL_FPU   = 3'd4,
    CL_CMOV  = 3'd5,
    CL_MEDIA = 3'd6,
    CL_SOLO  = 3'd7
  } cls_e;

  typedef enum logic [PIPE_W-1:0] {
    PP_NONE = 3'd0,
    PP_INT0 = 3'd1,
    PP_INT1 = 3'd2,
    PP_LDST = 3'd3,
    PP_BRN  = 3'd4,
    PP_FPU  = 3'd5,
    PP_CMOV = 3'd6,
    PP_BOTH = 3'd7
  } pipe_e;

  typedef struct packed {
    cls_e             cls;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] srca;
    logic [REG_W-1:0] srcb;
  } ins_t;

  function automatic logic is_int(cls_e c);
    return (c == CL_NOP) || (c == CL_ALU);
  endfunction

  function automatic pipe_e home_pipe(cls_e c);
    case (c)
      CL_LDST:  return PP_LDST;
      CL_BRN:   return PP_BRN;
      CL_FPU:   return PP_FPU;
      CL_CMOV:  return PP_CMOV;
      CL_MEDIA: return PP_BOTH;
      default:  return PP_INT0;
    endcase
  endfunction
endpackage

// File: rtl/dip_fetch.sv
module dip_fetch
  import dip_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:2]   start_word,
  input  logic            room,
  output logic            fetch_req,
  input  logic            fetch_gnt,
  output logic [AW-1:0]   fetch_addr,
  input  logic [INS_W-1:0] fetch_lo,
  input  logic [INS_W-1:0] fetch_hi,
  output logic [1:0]      push_n,
  output ins_t            push_d0,
  output ins_t            push_d1,
  output logic [AW-1:0]   push_pc0,
  output logic [AW-1:0]   push_pc1
);
  localparam int PIW = AW - 3;

  logic           active;
  logic           skip_lo;
  logic [PIW-1:0] pair_idx;
  logic           take;

  assign fetch_addr = {pair_idx, 3'b000};
  assign fetch_req  = active && room && !start;
  assign take       = fetch_req && fetch_gnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      skip_lo  <= 1'b0;
      pair_idx <= '0;
    end else if (start) begin
      active   <= 1'b1;
      pair_idx <= start_word[AW-1:3];
      skip_lo  <= start_word[2];
    end else if (take) begin
      pair_idx <= pair_idx + PIW'(1);
      skip_lo  <= 1'b0;
    end
  end

  always_comb begin
    push_n   = 2'd0;
    push_d0  = ins_t'(fetch_lo);
    push_d1  = ins_t'(fetch_hi);
    push_pc0 = {pair_idx, 3'b000};
    push_pc1 = {pair_idx, 3'b100};
    if (take) begin
      if (skip_lo) begin
        push_n   = 2'd1;
        push_d0  = ins_t'(fetch_hi);
        push_pc0 = {pair_idx, 3'b100};
      end else begin
        push_n = 2'd2;
      end
    end
  end

  a_r2_pair_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && fetch_gnt && !start) |=> (fetch_addr == $past(fetch_addr) + AW'(8)));

  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !fetch_gnt && !start) |=> (fetch_req && $stable(fetch_addr)));
endmodule

// File: rtl/dip_queue.sv
module dip_queue
  import dip_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DEPTH = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic [1:0]                push_n,
  input  ins_t                      push_d0,
  input  ins_t                      push_d1,
  input  logic [AW-1:0]             push_pc0,
  input  logic [AW-1:0]             push_pc1,
  input  logic [1:0]                pop_n,
  output ins_t                      head0,
  output ins_t                      head1,
  output logic [AW-1:0]             head_pc,
  output logic [$clog2(DEPTH):0]    count
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  ins_t          ins_mem [DEPTH];
  logic [AW-1:0] pc_mem  [DEPTH];
  logic [PW-1:0] rp, wp, wp1;

  assign wp1 = wp + PW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp    <= '0;
      wp    <= '0;
      count <= '0;
    end else if (flush) begin
      rp    <= '0;
      wp    <= '0;
      count <= '0;
    end else begin
      rp    <= rp + PW'(pop_n);
      wp    <= wp + PW'(push_n);
      count <= count + CW'(push_n) - CW'(pop_n);
    end
  end

  always_ff @(posedge clk) begin
    if (!flush && push_n != 2'd0) begin
      ins_mem[wp] <= push_d0;
      pc_mem[wp]  <= push_pc0;
    end
    if (!flush && push_n == 2'd2) begin
      ins_mem[wp1] <= push_d1;
      pc_mem[wp1]  <= push_pc1;
    end
  end

  assign head0   = ins_mem[rp];
  assign head1   = ins_mem[rp + PW'(1)];
  assign head_pc = pc_mem[rp];

  a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> (int'(count) + int'(push_n) - int'(pop_n) <= DEPTH));

  a_r11_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> (int'(pop_n) <= int'(count)));
endmodule

// File: rtl/dip_pair.sv
module dip_pair
  import dip_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  v0,
  input  logic  v1,
  input  ins_t  i0,
  input  ins_t  i1,
  output logic  dual,
  output pipe_e p0,
  output pipe_e p1
);
  function automatic logic [1:0] int_need(cls_e c);
    if (is_int(c))         return 2'd1;
    else if (c == CL_MEDIA) return 2'd2;
    else                   return 2'd0;
  endfunction

  logic [2:0] int_sum;
  logic       dep, clash, excl;
  logic       cop0, cop1;

  always_comb begin
    int_sum = {1'b0, int_need(i0.cls)} + {1'b0, int_need(i1.cls)};
    cop0    = (i0.cls == CL_FPU) || (i0.cls == CL_CMOV);
    cop1    = (i1.cls == CL_FPU) || (i1.cls == CL_CMOV);
    dep     = (i0.dst != '0) && ((i0.dst == i1.srca) || (i0.dst == i1.srcb));
    clash   = (int_sum > 3'd2)
            || ((i0.cls == CL_LDST) && (i1.cls == CL_LDST))
            || ((i0.cls == CL_BRN)  && (i1.cls == CL_BRN))
            || (cop0 && cop1);
    excl    = (i0.cls == CL_SOLO) || (i1.cls == CL_SOLO)
            || ((i0.cls == CL_FPU)   && (i1.cls == CL_MEDIA))
            || ((i0.cls == CL_MEDIA) && (i1.cls == CL_FPU));
    dual    = v0 && v1 && !dep && !clash && !excl;
    p0      = v0 ? home_pipe(i0.cls) : PP_NONE;
    if (!dual)
      p1 = PP_NONE;
    else if (is_int(i1.cls))
      p1 = is_int(i0.cls) ? PP_INT1 : PP_INT0;
    else
      p1 = home_pipe(i1.cls);
  end

  a_r3_distinct_pipes: assert property (@(posedge clk) disable iff (!rst_n)
    dual |-> (p0 != p1));

  a_r4_single_fpu: assert property (@(posedge clk) disable iff (!rst_n)
    dual |-> !((p0 == PP_FPU) && (p1 == PP_FPU)));

  a_r5_media_partner: assert property (@(posedge clk) disable iff (!rst_n)
    (dual && (p0 == PP_BOTH)) |->
      ((p1 == PP_LDST) || (p1 == PP_BRN) || (p1 == PP_CMOV)));
endmodule

// File: rtl/dual_issue_pairer.sv
module dual_issue_pairer
  import dip_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:2]     start_addr,
  output logic              fetch_req,
  input  logic              fetch_gnt,
  output logic [AW-1:0]     fetch_addr,
  input  logic [17:0]       fetch_lo,
  input  logic [17:0]       fetch_hi,
  output logic              iss_valid,
  input  logic              iss_ready,
  output logic              iss_dual,
  output logic [AW-1:0]     iss_pc,
  output logic [2:0]        iss_pipe0,
  output logic [2:0]        iss_pipe1
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic [1:0]    push_n, pop_n;
  ins_t          push_d0, push_d1, head0, head1;
  logic [AW-1:0] push_pc0, push_pc1, head_pc;
  logic [CW-1:0] count;
  logic          room, hv0, hv1, load;
  logic          pr_dual;
  pipe_e         pr_p0, pr_p1;

  assign room = count <= CW'(DEPTH - 2);
  assign hv0  = count >= CW'(1);
  assign hv1  = count >= CW'(2);
  assign load = (!iss_valid || iss_ready) && !start;

  always_comb begin
    pop_n = 2'd0;
    if (load && hv0) pop_n = pr_dual ? 2'd2 : 2'd1;
  end

  dip_fetch #(.AW(AW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .start(start), .start_word(start_addr),
    .room(room), .fetch_req(fetch_req), .fetch_gnt(fetch_gnt),
    .fetch_addr(fetch_addr), .fetch_lo(fetch_lo), .fetch_hi(fetch_hi),
    .push_n(push_n), .push_d0(push_d0), .push_d1(push_d1),
    .push_pc0(push_pc0), .push_pc1(push_pc1)
  );

  dip_queue #(.AW(AW), .DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .flush(start),
    .push_n(push_n), .push_d0(push_d0), .push_d1(push_d1),
    .push_pc0(push_pc0), .push_pc1(push_pc1),
    .pop_n(pop_n), .head0(head0), .head1(head1), .head_pc(head_pc),
    .count(count)
  );

  dip_pair u_pair (
    .clk(clk), .rst_n(rst_n), .v0(hv0), .v1(hv1), .i0(head0), .i1(head1),
    .dual(pr_dual), .p0(pr_p0), .p1(pr_p1)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iss_valid <= 1'b0;
      iss_dual  <= 1'b0;
      iss_pc    <= '0;
      iss_pipe0 <= '0;
      iss_pipe1 <= '0;
    end else if (start) begin
      iss_valid <= 1'b0;
    end else if (load) begin
      iss_valid <= hv0;
      iss_dual  <= pr_dual;
      iss_pc    <= head_pc;
      iss_pipe0 <= pr_p0;
      iss_pipe1 <= pr_p1;
    end
  end

  a_r11_group_held: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready && !start) |=>
      (iss_valid && $stable(iss_pc) && $stable(iss_dual)
       && $stable(iss_pipe0) && $stable(iss_pipe1)));

  a_r8_next_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready && !start) |=>
      (!iss_valid || iss_pc == $past(iss_pc) + ($past(iss_dual) ? AW'(8) : AW'(4))));

  a_r9_single_no_second: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_dual) |-> (iss_pipe1 == 3'd0));
endmodule

// File: tb/dual_issue_pairer_test.sv
module dual_issue_pairer_test;
  localparam int AW = 16;
  localparam logic [17:0] FILL = {3'd1, 15'd0};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:2] start_addr = '0;
  logic          fetch_req, fetch_gnt = 1'b1;
  logic [AW-1:0] fetch_addr;
  logic [17:0]   fetch_lo, fetch_hi;
  logic          iss_valid, iss_ready = 1'b0, iss_dual;
  logic [AW-1:0] iss_pc;
  logic [2:0]    iss_pipe0, iss_pipe1;

  logic          sweep = 1'b0;
  logic [17:0]   prog_a = FILL, prog_b = FILL;
  int            n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  dual_issue_pairer #(.AW(AW), .DEPTH(4)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .fetch_req(fetch_req), .fetch_gnt(fetch_gnt), .fetch_addr(fetch_addr),
    .fetch_lo(fetch_lo), .fetch_hi(fetch_hi),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_dual(iss_dual),
    .iss_pc(iss_pc), .iss_pipe0(iss_pipe0), .iss_pipe1(iss_pipe1)
  );

  function automatic logic [17:0] word_at(logic [AW-1:0] a);
    if (sweep && a == 16'h0000) return prog_a;
    if (sweep && a == 16'h0004) return prog_b;
    return FILL;
  endfunction

  always_comb begin
    fetch_lo = word_at(fetch_addr);
    fetch_hi = word_at(fetch_addr + 16'd4);
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start(logic [AW-1:0] byte_addr);
    @(negedge clk);
    start = 1'b1;
    start_addr = byte_addr[AW-1:2];
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_valid(string req);
    for (int k = 0; k < 12; k++) begin
      if (iss_valid) break;
      @(negedge clk);
    end
    chk(req, 32'(iss_valid), 32'd1);
  endtask

  function automatic bit may_pair(int c0, int c1);
    case (c0)
      0, 1:    return c1 inside {0, 1, 2, 3, 4, 5};
      2:       return c1 inside {0, 1, 3, 4, 5, 6};
      3:       return c1 inside {0, 1, 2, 4, 5, 6};
      4:       return c1 inside {0, 1, 2, 3};
      5:       return c1 inside {0, 1, 2, 3, 6};
      6:       return c1 inside {2, 3, 5};
      default: return 1'b0;
    endcase
  endfunction

  function automatic int own_pipe(int c);
    case (c)
      2: return 3;
      3: return 4;
      4: return 5;
      5: return 6;
      6: return 7;
      default: return 1;
    endcase
  endfunction

  function automatic string tag_for(int c0, int c1, int v);
    if (v == 1 || v == 2 || v == 3) return "R7";
    if (c0 == 7 || c1 == 7) return "R6";
    if (c0 == 6 || c1 == 6) return "R5";
    if (c0 == 4 || c1 == 4) return "R4";
    if (c0 <= 1 && c1 <= 1) return "R3";
    return "R6";
  endfunction

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [AW-1:0] nxt;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 32'(iss_valid), 32'd0);
    chk("R1 req in reset", 32'(fetch_req), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 valid idle", 32'(iss_valid), 32'd0);
    chk("R1 req idle", 32'(fetch_req), 32'd0);

    // Pairing sweep: every class pair, four register relations.
    sweep = 1'b1;
    iss_ready = 1'b1;
    for (int ca = 0; ca < 8; ca++) begin
      for (int cb = 0; cb < 8; cb++) begin
        for (int v = 0; v < 4; v++) begin
          bit pairs, dep;
          int ep1;
          string tg;
          logic [4:0] da, sa, sb;
          da = (v == 3) ? 5'd0 : 5'd3;
          sa = (v == 1) ? 5'd3 : ((v == 3) ? 5'd0 : 5'd4);
          sb = (v == 2) ? 5'd3 : ((v == 3) ? 5'd0 : 5'd5);
          prog_a = {3'(ca), da, 5'd6, 5'd7};
          prog_b = {3'(cb), 5'd8, sa, sb};
          dep = (v == 1) || (v == 2);
          pairs = may_pair(ca, cb) && !dep;
          tg = tag_for(ca, cb, v);
          do_start(16'h0000);
          wait_valid("R12 sweep start");
          chk("R12 first pc", 32'(iss_pc), 32'h0);
          chk(tg, 32'(iss_dual), 32'(pairs));
          chk("R9 pipe0", 32'(iss_pipe0), 32'(own_pipe(ca)));
          if (!pairs) ep1 = 0;
          else if (cb <= 1) ep1 = (ca <= 1) ? 2 : 1;
          else ep1 = own_pipe(cb);
          chk("R9 pipe1", 32'(iss_pipe1), 32'(ep1));
          if (!pairs) begin
            @(negedge clk);
            chk("R8 younger leads", 32'(iss_pc), 32'h4);
            chk("R8 younger valid", 32'(iss_valid), 32'd1);
          end
        end
      end
    end
    sweep = 1'b0;

    // R10 aligned start: 4 dual groups on consecutive cycles.
    do_start(16'h0100);
    chk("R2 first fetch aligned", 32'(fetch_addr), 32'h0100);
    wait_valid("R10 aligned");
    for (int k = 0; k < 4; k++) begin
      chk("R10 aligned pc", 32'(iss_pc), 32'h0100 + 32'(8 * k));
      chk("R10 aligned dual", 32'({iss_valid, iss_dual}), 32'd3);
      @(negedge clk);
    end

    // R10 unaligned start: lone first group, then pairs across fetch pairs.
    do_start(16'h0104);
    chk("R2 rounded fetch", 32'(fetch_addr), 32'h0100);
    wait_valid("R10 unaligned");
    chk("R2 low word dropped", 32'(iss_pc), 32'h0104);
    chk("R10 first single", 32'(iss_dual), 32'd0);
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      chk("R10 straddle pc", 32'(iss_pc), 32'h0108 + 32'(8 * k));
      chk("R10 straddle dual", 32'({iss_valid, iss_dual}), 32'd3);
      @(negedge clk);
    end

    // R11 stall: group held.
    iss_ready = 1'b0;
    do_start(16'h0200);
    wait_valid("R11 stall start");
    for (int k = 0; k < 5; k++) begin
      chk("R11 held pc", 32'(iss_pc), 32'h0200);
      chk("R11 held valid", 32'(iss_valid), 32'd1);
      @(negedge clk);
    end

    // R11 accept and fetch grant colliding in varied patterns.
    nxt = 16'h0200;
    for (int k = 0; k < 120; k++) begin
      bit r;
      r = (k % 3) != 0;
      if (iss_valid) begin
        chk("R11 consecutive pc", 32'(iss_pc), 32'(nxt));
        chk("R11 dual", 32'(iss_dual), 32'd1);
      end
      if (iss_valid && r) nxt = nxt + (iss_dual ? 16'd8 : 16'd4);
      iss_ready = r;
      fetch_gnt = (k % 5) != 2;
      @(negedge clk);
    end
    fetch_gnt = 1'b1;

    // R12 redirect while stalled.
    iss_ready = 1'b0;
    @(negedge clk);
    do_start(16'h0300);
    wait_valid("R12 redirect");
    chk("R12 new pc", 32'(iss_pc), 32'h0300);
    iss_ready = 1'b1;
    @(negedge clk);
    chk("R12 continues", 32'(iss_pc), 32'h0308);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule